// File: doc/BRIEF.md
# Prefixed Move Instruction Decoder

This block decodes the fixed 16-bit instruction words of an accumulator-based core in which every operation is a move from one register to another. Each word is split into a source and a destination. The source is either an 8-bit literal or a register named by a module and an index. The destination is always a module and an index. The decoded fields are combinational outputs that appear in the same cycle as the word. They are meant to drive the register-transfer logic that follows.

A one-shot prefix register widens the fields of the single word that comes after it. It can supply the upper byte of the immediate, two extra destination index bits and one extra source index bit. An immediate-form move to a reserved destination module loads this register, and that move produces no transfer of its own. This is the one added cycle that a prefix costs. The prefix logic is a two-state machine:

- `PFX_EMPTY` moves to `PFX_ARMED` on a prefix write.
- `PFX_ARMED` returns to `PFX_EMPTY` on the next valid ordinary word.
- A second prefix write while in `PFX_ARMED` reloads the register and stays in `PFX_ARMED`.
- Both states hold when no word is valid.

Top module: `mvdec_top`

## Requirements
- R1: After reset, pfx_pending is 0 and all extension bits read as zero: imm16[15:8]=0, dst_idx[4:3]=0, src_idx[4]=0.
- R2: src_kind is 0 (immediate) when in_word[15] is 0, and 1 (register) when in_word[15] is 1.
- R3: imm16[7:0] equals in_word[7:0]. imm16[15:8] is the pending prefix high byte, or 0 when no prefix is pending.
- R4: src_mod equals in_word[3:0]. src_idx equals {src_ext, in_word[7:4]}, where src_ext is the pending prefix source extension bit, or 0.
- R5: dst_mod equals in_word[11:8]. dst_idx equals {dst_ext[1:0], in_word[14:12]}, where dst_ext is the pending prefix destination extension, or 0.
- R6: A prefix write is a valid word with in_word[15]=0 and in_word[11:8]=4'hB. It loads the prefix as follows: high byte = in_word[7:0], dst_ext = in_word[13:12], src_ext = in_word[14]. It drives xfer_valid to 0 in its own cycle, and pfx_pending reads 1 from the next cycle on.
- R7: The prefix is one-shot. The first valid ordinary word after a prefix write uses it, and after that word pfx_pending is 0 and the extensions read zero.
- R8: Cycles with in_valid=0 neither consume nor change a pending prefix.
- R9: A register-form word (in_word[15]=1) whose destination module is 4'hB is an ordinary transfer. It does not load the prefix.
- R10: A prefix write while a prefix is pending replaces the whole prefix value, and the prefix stays pending.
- R11: For every valid ordinary word, xfer_valid is 1. With in_valid=0, xfer_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 16 | Instruction word |
| xfer_valid | output | 1 | Word is a real transfer (not a prefix load) |
| src_kind | output | 1 | 0 immediate, 1 register |
| src_mod | output | 4 | Source module |
| src_idx | output | 5 | Extended source index |
| imm16 | output | 16 | Full immediate value |
| dst_mod | output | 4 | Destination module |
| dst_idx | output | 5 | Extended destination index |
| pfx_pending | output | 1 | A prefix waits for the next word |

## Verification
The bench checks that the prefix reaches exactly one following word. A design that fails to clear the prefix would leak the high byte or the extension bits into the second word. A design that consumes the prefix on idle cycles would lose it across a gap in the strobe. The bench also aims at the boundary of the reserved module. A decoder that ignores bit 15 would take a register-form move to module B as a prefix load and suppress its transfer. Finally, the bench places every prefix bit at its highest value and reloads a pending prefix, which exposes a misplaced extension bit or a partial overwrite.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
    localparam int WORD_W   = 16;
    localparam int MOD_W    = 4;
    localparam int LIT_W    = 8;
    localparam int SIDX_W   = 4;
    localparam int DIDX_W   = 3;
    localparam int SEXT_W   = 1;
    localparam int DEXT_W   = 2;
    localparam int PFX_W    = LIT_W + DEXT_W + SEXT_W;

    typedef enum logic [0:0] {
        PFX_EMPTY = 1'b0,
        PFX_ARMED = 1'b1
    } pfx_state_t;

    typedef struct packed {
        logic [SEXT_W-1:0] src_ext;
        logic [DEXT_W-1:0] dst_ext;
        logic [LIT_W-1:0]  hi_byte;
    } pfx_t;
endpackage

// File: rtl/mvdec_split.sv
module mvdec_split
    import mvdec_pkg::*;
#(
    parameter logic [MOD_W-1:0] PFX_MOD = 4'hB
) (
    input  logic [WORD_W-1:0]        word,
    input  pfx_t                     pfx,
    output logic                     is_pfx_wr,
    output logic                     kind,
    output logic [MOD_W-1:0]         s_mod,
    output logic [SIDX_W+SEXT_W-1:0] s_idx,
    output logic [WORD_W-1:0]        imm,
    output logic [MOD_W-1:0]         d_mod,
    output logic [DIDX_W+DEXT_W-1:0] d_idx,
    output pfx_t                     new_pfx
);
    localparam int DST_LO = LIT_W;
    localparam int DIX_LO = LIT_W + MOD_W;

    always_comb begin
        kind      = word[WORD_W-1];
        s_mod     = word[MOD_W-1:0];
        s_idx     = {pfx.src_ext, word[LIT_W-1:MOD_W]};
        imm       = {pfx.hi_byte, word[LIT_W-1:0]};
        d_mod     = word[DST_LO +: MOD_W];
        d_idx     = {pfx.dst_ext, word[DIX_LO +: DIDX_W]};
        is_pfx_wr = !kind && (d_mod == PFX_MOD);
        new_pfx.hi_byte = word[LIT_W-1:0];
        new_pfx.dst_ext = word[DIX_LO +: DEXT_W];
        new_pfx.src_ext = word[DIX_LO+DEXT_W +: SEXT_W];
    end
endmodule

// File: rtl/mvdec_pfx_fsm.sv
module mvdec_pfx_fsm
    import mvdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic is_pfx_wr,
    input  pfx_t new_pfx,
    output pfx_t cur_pfx,
    output logic pending
);
    pfx_state_t state, state_nx;
    pfx_t       pfx_q, pfx_nx;

    always_comb begin
        state_nx = state;
        pfx_nx   = pfx_q;
        unique case (state)
            PFX_EMPTY: begin
                if (in_valid && is_pfx_wr) begin
                    state_nx = PFX_ARMED;
                    pfx_nx   = new_pfx;
                end
            end
            PFX_ARMED: begin
                if (in_valid && is_pfx_wr) begin
                    state_nx = PFX_ARMED;
                    pfx_nx   = new_pfx;
                end else if (in_valid) begin
                    state_nx = PFX_EMPTY;
                    pfx_nx   = '0;
                end
            end
            default: begin
                state_nx = PFX_EMPTY;
                pfx_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PFX_EMPTY;
            pfx_q <= '0;
        end else begin
            state <= state_nx;
            pfx_q <= pfx_nx;
        end
    end

    always_comb begin
        pending = (state == PFX_ARMED);
        cur_pfx = pending ? pfx_q : '0;
    end

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_pfx_wr) |=> (pending && cur_pfx == $past(new_pfx)));
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && in_valid && !is_pfx_wr) |=> !pending);
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pending) && $stable(cur_pfx)));
endmodule

// File: rtl/mvdec_top.sv
module mvdec_top
    import mvdec_pkg::*;
#(
    parameter logic [MOD_W-1:0] PFX_MOD = 4'hB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [WORD_W-1:0]        in_word,
    output logic                     xfer_valid,
    output logic                     src_kind,
    output logic [MOD_W-1:0]         src_mod,
    output logic [SIDX_W+SEXT_W-1:0] src_idx,
    output logic [WORD_W-1:0]        imm16,
    output logic [MOD_W-1:0]         dst_mod,
    output logic [DIDX_W+DEXT_W-1:0] dst_idx,
    output logic                     pfx_pending
);
    pfx_t cur_pfx, new_pfx;
    logic is_pfx_wr;

    mvdec_split #(.PFX_MOD(PFX_MOD)) u_split (
        .word      (in_word),
        .pfx       (cur_pfx),
        .is_pfx_wr (is_pfx_wr),
        .kind      (src_kind),
        .s_mod     (src_mod),
        .s_idx     (src_idx),
        .imm       (imm16),
        .d_mod     (dst_mod),
        .d_idx     (dst_idx),
        .new_pfx   (new_pfx)
    );

    mvdec_pfx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .is_pfx_wr (is_pfx_wr),
        .new_pfx   (new_pfx),
        .cur_pfx   (cur_pfx),
        .pending   (pfx_pending)
    );

    assign xfer_valid = in_valid && !is_pfx_wr;

    p_ext_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pfx_pending |-> (imm16[WORD_W-1:LIT_W] == '0 &&
                          dst_idx[DIDX_W+DEXT_W-1:DIDX_W] == '0 &&
                          src_idx[SIDX_W+SEXT_W-1:SIDX_W] == '0));
    p_no_xfer_pfx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (in_word[WORD_W-1] || dst_mod != PFX_MOD));
    p_reg_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-1] && !pfx_pending) |=> !pfx_pending);
endmodule

// File: tb/mvdec_top_test.sv
module mvdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0000;
    logic        xfer_valid, src_kind, pfx_pending;
    logic [3:0]  src_mod, dst_mod;
    logic [4:0]  src_idx, dst_idx;
    logic [15:0] imm16;

    int n_chk = 0;
    int n_bad = 0;
    bit m_pend = 0;
    logic [7:0] m_hi = 0;
    logic [1:0] m_dx = 0;
    logic       m_sx = 0;

    mvdec_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .xfer_valid(xfer_valid), .src_kind(src_kind), .src_mod(src_mod),
        .src_idx(src_idx), .imm16(imm16), .dst_mod(dst_mod),
        .dst_idx(dst_idx), .pfx_pending(pfx_pending)
    );

    always #10 clk = ~clk;

    task automatic apply(input logic v, input logic [15:0] w, input string tag);
        logic [36:0] exp_v, act_v;
        logic pw;
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        #2;
        pw = v && !w[15] && (w[11:8] == 4'hB);
        exp_v = {v && !pw, w[15], w[3:0], m_sx, w[7:4], m_hi, w[7:0],
                 w[11:8], m_dx, w[14:12], m_pend};
        act_v = {xfer_valid, src_kind, src_mod, src_idx, imm16, dst_mod,
                 dst_idx, pfx_pending};
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act_v, exp_v);
        end
        if (pw) begin
            m_pend = 1; m_hi = w[7:0]; m_dx = w[13:12]; m_sx = w[14];
        end else if (v) begin
            m_pend = 0; m_hi = 0; m_dx = 0; m_sx = 0;
        end
    endtask

    task automatic t_reset();
        apply(0, 16'h0000, "R1 reset state");
        apply(0, 16'hFFFF, "R1 idle extensions zero");
    endtask

    task automatic t_plain();
        apply(1, 16'h3A5C, "R2 R3 R5 immediate move");
        apply(1, 16'h7F00, "R5 R11 max unprefixed dst index");
        apply(1, 16'hC2E7, "R2 R4 register move");
        apply(1, 16'h8FF0, "R4 R11 max unprefixed src index");
    endtask

    task automatic t_prefix_imm();
        apply(1, 16'h0BAB, "R6 prefix write high byte");
        apply(1, 16'h2312, "R3 R7 prefixed immediate");
        apply(1, 16'h2312, "R7 prefix consumed");
    endtask

    task automatic t_prefix_idx();
        apply(1, 16'h7BFF, "R6 prefix write all ext bits");
        apply(1, 16'hF5F3, "R4 R5 R7 prefixed register move");
        apply(1, 16'hF5F3, "R7 extensions cleared");
    endtask

    task automatic t_gap();
        apply(1, 16'h5B01, "R6 prefix before gap");
        apply(0, 16'h1234, "R8 idle cycle one");
        apply(0, 16'h0B77, "R8 idle prefix-shaped word ignored");
        apply(1, 16'h1240, "R8 R7 prefix survives gap");
        apply(0, 16'h0000, "R8 R11 idle after consume");
    endtask

    task automatic t_reg_pfxmod();
        apply(1, 16'hFB33, "R9 register move to module B");
        apply(1, 16'h0110, "R9 no prefix loaded");
    endtask

    task automatic t_reload();
        apply(1, 16'h7BEE, "R10 first prefix");
        apply(1, 16'h0B11, "R10 reload prefix");
        apply(1, 16'hE0F0, "R10 R7 reloaded value used");
        apply(1, 16'h0000, "R7 R11 after reload consumed");
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_prefix_imm();
        t_prefix_idx();
        t_gap();
        t_reg_pfxmod();
        t_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule